// File: doc/BRIEF.md
# SCSI DMA Transfer Counter

This block is the transfer-count engine on the DMA path of a SCSI controller. The host programs a 16-bit byte count one byte at a time into shadow registers. A command that carries the load flag copies the shadow value into the live counter. When the command is also a transfer command, the engine works out how many bytes this burst moves and raises a byte request. It then counts each acknowledged byte down. When the burst is finished, it writes the completion values into the controller's status, interrupt, sequence-step and FIFO-flag fields.

The burst length depends on the phase. In command phase it is the programmed count, capped at 32 bytes. Otherwise it is the smaller of the programmed count and the magnitude of a signed "remaining device bytes" input. The sign of that input gives the direction. A transfer from the device normally completes as soon as its burst is drained. If the device still reports more data pending at that point, completion is held back until the device signals the end of its chunk. Memory access, phase sequencing and the device buffer all sit outside this block.

Top module: `scsi_dma_cnt`

## Requirements
- R1: The live count `live_cnt` equals `{mid, lo}`, where `shd_we[0]` writes the low shadow byte and `shd_we[1]` writes the middle shadow byte. The live count is loaded from the shadow only when an idle cycle has `cmd_valid` and `cmd_load` both high; shadow writes by themselves leave `live_cnt` unchanged.
- R2: Outside command phase, the burst length placed in `burst_left` is min(count, |dev_remain|). `dev_remain` is two's complement. A negative value sets `to_dev` to 1; zero or a positive value sets it to 0.
- R3: In command phase (`cmd_phase`=1 at the start), the burst length is min(count, 32), `dev_remain` is ignored and `to_dev` is 1.
- R4: A transfer starts only on an idle cycle with `cmd_valid`, `cmd_load` and `cmd_xfer` all high. Starting raises `busy` and clears `stat_tc`. `cmd_xfer` without `cmd_load` starts nothing.
- R5: `byte_req` is high while busy and `burst_left` is nonzero. Each cycle with `byte_req` and `byte_ack` both high lowers both `burst_left` and `live_cnt` by one. `byte_ack` while `byte_req` is low has no effect.
- R6: A burst length of zero raises no `byte_req`. When no device data is pending, it completes on the cycle after the start.
- R7: On completion the engine sets `stat_tc`=1, `intr_code`=8'h10 (bus service, bit 4), `seq_step`=0, `fifo_flags`=0 and `live_cnt`=0, and returns to idle. `done` is high for exactly one cycle.
- R8: When a device-to-host, non-command burst drains with `dev_more`=1, the engine stays busy without `done` until a cycle with `dev_chunk`=1, and completes on that edge. With `dev_more`=0, or for a to-device or command-phase burst, it completes on the edge after the last acknowledge, whatever the value of `dev_more`.
- R9: `fld_we` loads `seq_step` from `fld_seq` and `fifo_flags` from `fld_flags`. `intr_clr` clears `intr_code` and `stat_tc`. Completion takes precedence over both.
- R10: Commands and their load flag are ignored while busy: `burst_left` and `live_cnt` are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shd_we | input | 2 | Per-byte shadow count write enables (bit 0 low, bit 1 middle) |
| shd_wdata | input | 8 | Shadow write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_load | input | 1 | Command carries the DMA/load flag |
| cmd_xfer | input | 1 | Command is a transfer command |
| cmd_phase | input | 1 | Bus is in command phase |
| dev_remain | input | 24 | Signed remaining device bytes (negative: toward device) |
| dev_more | input | 1 | Device holds further data beyond the current chunk |
| dev_chunk | input | 1 | Device finished its chunk (releases a held completion) |
| byte_ack | input | 1 | DMA byte acknowledge |
| fld_we | input | 1 | Write strobe for the sequence and FIFO-flag fields |
| fld_seq | input | 3 | Sequence-step write value |
| fld_flags | input | 5 | FIFO-flag write value |
| intr_clr | input | 1 | Clears the interrupt field and terminal count |
| byte_req | output | 1 | DMA byte request |
| live_cnt | output | 16 | Live transfer count |
| burst_left | output | 16 | Bytes remaining in the current burst |
| busy | output | 1 | Transfer in progress |
| to_dev | output | 1 | Direction of the current burst |
| stat_tc | output | 1 | Terminal-count status bit |
| intr_code | output | 8 | Interrupt field |
| seq_step | output | 3 | Sequence-step field |
| fifo_flags | output | 5 | FIFO-flag field |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the held completion. It needs a device-to-host burst outside command phase, a nonzero burst, and `dev_more` high at the moment the burst drains. While the engine waits in that state, the stimulus sends stray acknowledges and then releases it with `dev_chunk`. Random runs draw a mix of signed device lengths, command phase and pending-data settings, so held, immediate and zero-length completions all occur. Directed runs cover the most negative device length, the 32-byte cap and commands issued while busy.

// File: rtl/scsi_dma_cnt_pkg.sv
package scsi_dma_cnt_pkg;
  localparam int INTR_W = 8;
  localparam int SEQ_W  = 3;
  localparam int FLG_W  = 5;
  localparam logic [INTR_W-1:0] INTR_BUS_SERVICE = 8'h10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_HOLD = 2'd2
  } sdc_state_e;
endpackage

// File: rtl/sdc_count_regs.sv
module sdc_count_regs #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] shd_we,
  input  logic [BYTE_W-1:0] shd_wdata,
  input  logic              load,
  input  logic              dec,
  input  logic              clr,
  output logic [CNT_W-1:0]  shadow,
  output logic [CNT_W-1:0]  live
);
  logic [CNT_W-1:0] live_q, live_d;

  // One shadow byte per lane; lane b lands at bits [b*BYTE_W +: BYTE_W].
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] byte_q, byte_d;
    always_comb begin
      byte_d = byte_q;
      if (shd_we[b]) byte_d = shd_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign shadow[b*BYTE_W +: BYTE_W] = byte_q;
  end

  always_comb begin
    live_d = live_q;
    if (clr)       live_d = '0;
    else if (load) live_d = shadow;
    else if (dec)  live_d = live_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end

  assign live = live_q;
endmodule

// File: rtl/sdc_burst_len.sv
module sdc_burst_len #(
  parameter int CNT_W = 16,
  parameter int DEV_W = 24,
  parameter int CAP   = 32
) (
  input  logic                    cmd_phase,
  input  logic [CNT_W-1:0]        cnt,
  input  logic signed [DEV_W-1:0] dev_remain,
  output logic [CNT_W-1:0]        burst,
  output logic                    to_dev
);
  localparam int MAG_W = DEV_W + 1;
  localparam int CMP_W = (MAG_W > CNT_W) ? MAG_W : CNT_W;

  logic [MAG_W-1:0] ext, mag;
  logic [CMP_W-1:0] lim, cnt_x, sel;
  logic             neg;

  always_comb begin
    neg    = dev_remain[DEV_W-1];
    ext    = {dev_remain[DEV_W-1], dev_remain};
    mag    = neg ? (~ext + 1'b1) : ext;
    lim    = cmd_phase ? CMP_W'(CAP) : CMP_W'(mag);
    cnt_x  = CMP_W'(cnt);
    sel    = (cnt_x < lim) ? cnt_x : lim;
    burst  = sel[CNT_W-1:0];
    to_dev = cmd_phase | neg;
  end
endmodule

// File: rtl/sdc_xfer_fsm.sv
module sdc_xfer_fsm
  import scsi_dma_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_in,
  input  logic              to_dev_in,
  input  logic              byte_ack,
  input  logic              dev_more,
  input  logic              dev_chunk,
  input  logic              fld_we,
  input  logic [SEQ_W-1:0]  fld_seq,
  input  logic [FLG_W-1:0]  fld_flags,
  input  logic              intr_clr,
  output logic              byte_req,
  output logic              accept,
  output logic              finish,
  output logic [CNT_W-1:0]  burst_left,
  output logic              busy,
  output logic              to_dev,
  output logic              stat_tc,
  output logic [INTR_W-1:0] intr_code,
  output logic [SEQ_W-1:0]  seq_step,
  output logic [FLG_W-1:0]  fifo_flags,
  output logic              done
);
  sdc_state_e        st_q, st_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              dir_q, dir_d;
  logic              tc_q, tc_d;
  logic              done_q, done_d;
  logic [INTR_W-1:0] intr_q, intr_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [FLG_W-1:0]  flg_q, flg_d;
  logic              fin;

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    dir_d  = dir_q;
    tc_d   = tc_q;
    intr_d = intr_q;
    seq_d  = seq_q;
    flg_d  = flg_q;
    done_d = 1'b0;
    fin    = 1'b0;
    accept = 1'b0;

    if (fld_we) begin
      seq_d = fld_seq;
      flg_d = fld_flags;
    end
    if (intr_clr) begin
      intr_d = '0;
      tc_d   = 1'b0;
    end

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_MOVE;
          left_d = burst_in;
          dir_d  = to_dev_in;
          tc_d   = 1'b0;
        end
      end
      ST_MOVE: begin
        if (left_q != '0) begin
          if (byte_ack) begin
            left_d = left_q - 1'b1;
            accept = 1'b1;
          end
        end else if (dir_q || !dev_more) begin
          fin = 1'b1;
        end else begin
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (dev_chunk) fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (fin) begin
      st_d   = ST_IDLE;
      tc_d   = 1'b1;
      intr_d = INTR_BUS_SERVICE;
      seq_d  = '0;
      flg_d  = '0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      dir_q  <= 1'b0;
      tc_q   <= 1'b0;
      intr_q <= '0;
      seq_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      dir_q  <= dir_d;
      tc_q   <= tc_d;
      intr_q <= intr_d;
      seq_q  <= seq_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign finish     = fin;
  assign byte_req   = (st_q == ST_MOVE) && (left_q != '0);
  assign burst_left = left_q;
  assign busy       = (st_q != ST_IDLE);
  assign to_dev     = dir_q;
  assign stat_tc    = tc_q;
  assign intr_code  = intr_q;
  assign seq_step   = seq_q;
  assign fifo_flags = flg_q;
  assign done       = done_q;
endmodule

// File: rtl/scsi_dma_cnt.sv
module scsi_dma_cnt
  import scsi_dma_cnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int DEV_W  = 24,
  parameter int CAP    = 32,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBYTES-1:0]       shd_we,
  input  logic [BYTE_W-1:0]       shd_wdata,
  input  logic                    cmd_valid,
  input  logic                    cmd_load,
  input  logic                    cmd_xfer,
  input  logic                    cmd_phase,
  input  logic signed [DEV_W-1:0] dev_remain,
  input  logic                    dev_more,
  input  logic                    dev_chunk,
  input  logic                    byte_ack,
  input  logic                    fld_we,
  input  logic [SEQ_W-1:0]        fld_seq,
  input  logic [FLG_W-1:0]        fld_flags,
  input  logic                    intr_clr,
  output logic                    byte_req,
  output logic [CNT_W-1:0]        live_cnt,
  output logic [CNT_W-1:0]        burst_left,
  output logic                    busy,
  output logic                    to_dev,
  output logic                    stat_tc,
  output logic [INTR_W-1:0]       intr_code,
  output logic [SEQ_W-1:0]        seq_step,
  output logic [FLG_W-1:0]        fifo_flags,
  output logic                    done
);
  logic             load, start, accept, finish, dir_calc;
  logic [CNT_W-1:0] shadow, burst_calc;

  assign load  = cmd_valid && cmd_load && !busy;
  assign start = load && cmd_xfer;

  sdc_count_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .shd_we    (shd_we),
    .shd_wdata (shd_wdata),
    .load      (load),
    .dec       (accept),
    .clr       (finish),
    .shadow    (shadow),
    .live      (live_cnt)
  );

  sdc_burst_len #(.CNT_W(CNT_W), .DEV_W(DEV_W), .CAP(CAP)) u_len (
    .cmd_phase  (cmd_phase),
    .cnt        (shadow),
    .dev_remain (dev_remain),
    .burst      (burst_calc),
    .to_dev     (dir_calc)
  );

  sdc_xfer_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_in   (burst_calc),
    .to_dev_in  (dir_calc),
    .byte_ack   (byte_ack),
    .dev_more   (dev_more),
    .dev_chunk  (dev_chunk),
    .fld_we     (fld_we),
    .fld_seq    (fld_seq),
    .fld_flags  (fld_flags),
    .intr_clr   (intr_clr),
    .byte_req   (byte_req),
    .accept     (accept),
    .finish     (finish),
    .burst_left (burst_left),
    .busy       (busy),
    .to_dev     (to_dev),
    .stat_tc    (stat_tc),
    .intr_code  (intr_code),
    .seq_step   (seq_step),
    .fifo_flags (fifo_flags),
    .done       (done)
  );
endmodule

// File: rtl/scsi_dma_cnt_chk.sv
module scsi_dma_cnt_chk #(
  parameter int CNT_W = 16,
  parameter int CAP   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_load,
  input logic             cmd_phase,
  input logic             byte_ack,
  input logic             byte_req,
  input logic             busy,
  input logic [CNT_W-1:0] burst_left,
  input logic [CNT_W-1:0] live_cnt,
  input logic             stat_tc,
  input logic [7:0]       intr_code,
  input logic [2:0]       seq_step,
  input logic [4:0]       fifo_flags,
  input logic             done
);
  p_live_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(cmd_valid && cmd_load)) |-> $stable(live_cnt));

  p_cmd_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cmd_phase)) |-> (burst_left <= CAP));

  p_start_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !stat_tc);

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> busy);

  p_ack_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && byte_ack) |=> (burst_left == $past(burst_left) - 1'b1));

  p_done_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat_tc && intr_code == 8'h10 && seq_step == '0 &&
              fifo_flags == '0 && live_cnt == '0 && !busy));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind scsi_dma_cnt scsi_dma_cnt_chk #(.CNT_W(CNT_W), .CAP(CAP)) u_chk (.*);

// File: tb/scsi_dma_cnt_bench.sv
module scsi_dma_cnt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  shd_we;
  logic [7:0]  shd_wdata;
  logic        cmd_valid, cmd_load, cmd_xfer, cmd_phase;
  logic signed [23:0] dev_remain;
  logic        dev_more, dev_chunk, byte_ack;
  logic        fld_we;
  logic [2:0]  fld_seq;
  logic [4:0]  fld_flags;
  logic        intr_clr;
  logic        byte_req, busy, to_dev, stat_tc, done;
  logic [15:0] live_cnt, burst_left;
  logic [7:0]  intr_code;
  logic [2:0]  seq_step;
  logic [4:0]  fifo_flags;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  scsi_dma_cnt u_scsi_dma_cnt (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_burst(int cnt, int remain, bit phase);
    int lim;
    lim = phase ? 32 : ((remain < 0) ? -remain : remain);
    return (cnt < lim) ? cnt : lim;
  endfunction

  task automatic write_shadow(input int cnt);
    @(negedge clk); shd_we = 2'b01; shd_wdata = cnt[7:0];
    @(negedge clk); shd_we = 2'b10; shd_wdata = cnt[15:8];
    @(negedge clk); shd_we = 2'b00;
  endtask

  task automatic run_xfer(input int cnt, input int remain, input bit phase,
                          input bit more, input bit poke);
    int  eb, acks;
    bit  edir, imm;
    eb   = exp_burst(cnt, remain, phase);
    edir = phase || (remain < 0);
    imm  = edir || !more;
    write_shadow(cnt);
    fld_we = 1'b1; fld_seq = 3'd5; fld_flags = 5'd9;
    dev_more = more; dev_remain = 24'(remain);
    @(negedge clk); fld_we = 1'b0;
    chk(seq_step == 3'd5 && fifo_flags == 5'd9, "R9 field write", seq_step, 5);
    cmd_valid = 1'b1; cmd_load = 1'b1; cmd_xfer = 1'b1; cmd_phase = phase;
    @(negedge clk); cmd_valid = 1'b0; cmd_phase = 1'b0;
    chk(busy == 1'b1, "R4 busy after start", busy, 1);
    chk(stat_tc == 1'b0, "R4 tc cleared at start", stat_tc, 0);
    chk(burst_left == 16'(eb), phase ? "R3 capped burst" : "R2 burst length", burst_left, eb);
    chk(to_dev == edir, "R2 direction", to_dev, edir);
    chk(live_cnt == 16'(cnt), "R1 live count loaded", live_cnt, cnt);
    chk(byte_req == (eb != 0), "R6 request vs burst", byte_req, eb != 0);
    if (poke && eb > 1) begin
      shd_we = 2'b11; shd_wdata = 8'hEE;
      cmd_valid = 1'b1; cmd_load = 1'b1; cmd_xfer = 1'b1;
      @(negedge clk); cmd_valid = 1'b0; shd_we = 2'b00;
      chk(burst_left == 16'(eb), "R10 busy command ignored (burst)", burst_left, eb);
      chk(live_cnt == 16'(cnt), "R10 busy command ignored (count)", live_cnt, cnt);
    end
    acks = 0;
    while (byte_req) begin
      automatic bit a = ($urandom % 4) != 0;
      byte_ack = a;
      @(negedge clk); byte_ack = 1'b0;
      if (a) acks++;
      if (acks > 70000) break;
    end
    chk(acks == eb, "R5 acknowledged byte count", acks, eb);
    chk(live_cnt == 16'(cnt - eb), "R5 live count after burst", live_cnt, cnt - eb);
    if (!imm) begin
      @(negedge clk);
      chk(busy && !done, "R8 completion held", done, 0);
      byte_ack = 1'b1;
      repeat (2) @(negedge clk);
      byte_ack = 1'b0;
      chk(burst_left == 16'd0 && live_cnt == 16'(cnt - eb), "R5 stray ack ignored", live_cnt, cnt - eb);
      chk(busy && !done, "R8 still held", busy, 1);
      dev_chunk = 1'b1;
      @(negedge clk); dev_chunk = 1'b0;
    end else begin
      @(negedge clk);
    end
    chk(done == 1'b1, imm ? "R8 immediate completion" : "R8 released completion", done, 1);
    chk(stat_tc == 1'b1 && !busy, "R7 tc set", stat_tc, 1);
    chk(intr_code == 8'h10, "R7 bus service", intr_code, 16);
    chk(seq_step == 3'd0 && fifo_flags == 5'd0, "R7 fields cleared", seq_step, 0);
    chk(live_cnt == 16'd0, "R7 count cleared", live_cnt, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; shd_we = '0; shd_wdata = '0;
    cmd_valid = 0; cmd_load = 0; cmd_xfer = 0; cmd_phase = 0;
    dev_remain = '0; dev_more = 0; dev_chunk = 0; byte_ack = 0;
    fld_we = 0; fld_seq = '0; fld_flags = '0; intr_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !byte_req && !done, "R4 idle after reset", busy, 0);
    chk(live_cnt == 0 && burst_left == 0, "R1 reset count", live_cnt, 0);
    chk(stat_tc == 0 && intr_code == 0, "R7 reset status", intr_code, 0);

    // R1: shadow writes alone do not reach the live count
    write_shadow(16'h1234);
    chk(live_cnt == 16'd0, "R1 shadow write isolated", live_cnt, 0);
    cmd_valid = 1; cmd_load = 1; cmd_xfer = 0;
    @(negedge clk); cmd_valid = 0;
    chk(live_cnt == 16'h1234, "R1 load without transfer", live_cnt, 16'h1234);
    chk(!busy, "R4 load alone does not start", busy, 0);
    cmd_valid = 1; cmd_load = 0; cmd_xfer = 1;
    @(negedge clk); cmd_valid = 0;
    chk(!busy && !byte_req, "R4 transfer without load ignored", busy, 0);

    // directed corners
    run_xfer(50, 20, 0, 0, 0);
    run_xfer(10, -100, 0, 1, 0);
    run_xfer(1000, 5, 1, 1, 0);
    run_xfer(0, 30, 0, 0, 0);          // R6 zero count
    run_xfer(20, 0, 0, 0, 0);          // R6 zero device length
    run_xfer(40, -(1 << 23), 0, 0, 0); // most negative device length
    run_xfer(30, 100, 0, 1, 0);        // R8 held completion
    run_xfer(300, 200, 0, 0, 0);       // middle byte in use
    run_xfer(20, 50, 0, 0, 1);         // R10 command while busy

    // R9: interrupt clear
    @(negedge clk); intr_clr = 1'b1;
    @(negedge clk); intr_clr = 1'b0;
    chk(intr_code == 8'h00 && stat_tc == 1'b0, "R9 interrupt clear", intr_code, 0);

    for (int i = 0; i < 40; i++) begin
      automatic int  c = ($urandom % 5 == 0) ? 0 : int'($urandom % 600);
      automatic int  r = int'($urandom % 241) - 120;
      automatic bit  p = ($urandom % 5) == 0;
      automatic bit  m = $urandom % 2;
      run_xfer(c, r, p, m, ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule